// File: doc/BRIEF.md
# Convergent Cellular Automaton Logic Cell

This block is one identical tile of a self-assembling logic array. On every clock edge it takes the state values offered by its north and west neighbours, looks up its own next state in a fixed rule table, and hands that single state value on to both its east and south neighbours. The cell's own present state never feeds the rule. Because of this, a chain of such cells settles to one pattern no matter how it started. If part of the array is disturbed, the same process rebuilds the pattern.

Each state names one small logic function. The function is held as an 8-bit configuration word: two 4-entry truth tables, one per logic output. When the cell's state changes, a comparator notices the change. For one cycle the cell is busy, and during that cycle it copies the new configuration word into its execution table. The two logic outputs are registered and keep their previous values while the copy is under way. After the copy, they follow the two logic inputs through the new table. Data moves only forward, from logic inputs to logic outputs. Apart from the clock and the active-low reset, no global signal is used.

Top module: `ca_logic_cell`

## Requirements
- R1: While reset is asserted, the state outputs are 0, the reload-busy flag is 0 and both logic outputs are 0.
- R2: After each rising edge, the state equals (north + 2*west + 1) mod 16, computed from the neighbour inputs present at that edge. The cell's previous state has no influence on it.
- R3: The east and south state outputs always carry the same value.
- R4: If an edge gives the state a value different from its previous one, the reload-busy flag is 1 for the following cycle. If the state is unchanged, the flag is 0.
- R5: The configuration word for state 0 is 8'h00. For any other state s, bits [3:0] equal s and bits [7:4] equal the bitwise inverse of s. Logic output 0 is bit {in1,in0} of bits [3:0]. Logic output 1 is bit {in1,in0} of bits [7:4].
- R6: At an edge where the reload-busy flag is 1, the logic outputs keep their values, whatever the logic inputs are.
- R7: Take a state change that lands at edge k and no further change. From edge k+2 on, the logic outputs show the new state's functions applied to the logic inputs sampled at each edge.
- R8: While the state stays the same, no reload takes place. The logic outputs follow the logic inputs with one edge of latency.
- R9: When the state changes on consecutive edges, each change brings its own busy cycle. The function that finally takes effect is the one for the last state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Global reset, active low, synchronous |
| north_state_i | input | 4 | State offered by the north neighbour |
| west_state_i | input | 4 | State offered by the west neighbour |
| east_state_o | output | 4 | Cell state towards the east neighbour |
| south_state_o | output | 4 | Cell state towards the south neighbour (same value) |
| logic_i | input | 2 | Logic inputs; bit 1 is in1, bit 0 is in0 |
| logic_o | output | 2 | Registered logic outputs |
| reload_busy_o | output | 1 | High for the cycle in which the execution table is reloaded |

## Verification
The main function is first driven with neighbour values that produce the exclusive-or, AND and OR truth tables, and then the all-zero table of state 0. All four logic input combinations are swept under each table. This separates the two output tables, shows the bit ordering of the index, and exposes a wrong entry in the function store. Holding the neighbour values steady while only the logic inputs move shows that a reload happens only on a real change and that the output latency is one edge. Toggling the logic inputs during a busy cycle shows that the outputs hold. Changing the neighbours on back-to-back edges, and reaching the same neighbour pair from different present states, shows that the last state decides the function and that the rule never reads the cell's own state.

// File: rtl/ca_cell_pkg.sv
package ca_cell_pkg;
  localparam int unsigned DEF_STATE_W = 4;
  localparam int unsigned DEF_NUM_IN  = 2;
  localparam int unsigned DEF_NUM_OUT = 2;
endpackage

// File: rtl/ca_rule_lut.sv
module ca_rule_lut #(
  parameter int unsigned STATE_W = ca_cell_pkg::DEF_STATE_W
) (
  input  logic [STATE_W-1:0] north_i,
  input  logic [STATE_W-1:0] west_i,
  output logic [STATE_W-1:0] next_o
);
  localparam int unsigned IDX_W   = 2 * STATE_W;
  localparam int unsigned ENTRIES = 1 << IDX_W;

  logic [STATE_W-1:0] table_w [ENTRIES];

  // Rule table built at elaboration: entry {n,w} = n + 2w + 1 (mod 2^STATE_W)
  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    localparam logic [IDX_W-1:0] IDX = IDX_W'(g);
    localparam logic [STATE_W-1:0] NV = IDX[IDX_W-1:STATE_W];
    localparam logic [STATE_W-1:0] WV = IDX[STATE_W-1:0];
    assign table_w[g] = STATE_W'(NV + (WV << 1) + STATE_W'(1));
  end

  assign next_o = table_w[{north_i, west_i}];
endmodule

// File: rtl/ca_func_store.sv
module ca_func_store #(
  parameter int unsigned STATE_W = ca_cell_pkg::DEF_STATE_W,
  parameter int unsigned NUM_IN  = ca_cell_pkg::DEF_NUM_IN,
  parameter int unsigned NUM_OUT = ca_cell_pkg::DEF_NUM_OUT
) (
  input  logic [STATE_W-1:0]               state_i,
  output logic [NUM_OUT*(1<<NUM_IN)-1:0]   cfg_o
);
  localparam int unsigned TT_W     = 1 << NUM_IN;
  localparam int unsigned CFG_W    = NUM_OUT * TT_W;
  localparam int unsigned N_STATES = 1 << STATE_W;

  logic [CFG_W-1:0] store_w [N_STATES];

  // State 0 is the idle all-zero function; otherwise even tables copy the
  // state code, odd tables carry its inverse.
  for (genvar s = 0; s < N_STATES; s++) begin : g_state
    localparam logic [TT_W-1:0] TT = TT_W'(s);
    for (genvar o = 0; o < NUM_OUT; o++) begin : g_tab
      if (s == 0) begin : g_idle
        assign store_w[s][o*TT_W +: TT_W] = '0;
      end else if (o % 2 == 0) begin : g_true
        assign store_w[s][o*TT_W +: TT_W] = TT;
      end else begin : g_inv
        assign store_w[s][o*TT_W +: TT_W] = ~TT;
      end
    end
  end

  assign cfg_o = store_w[state_i];
endmodule

// File: rtl/ca_reload_ctrl.sv
module ca_reload_ctrl #(
  parameter int unsigned STATE_W = ca_cell_pkg::DEF_STATE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STATE_W-1:0] north_i,
  input  logic [STATE_W-1:0] west_i,
  input  logic [STATE_W-1:0] next_i,
  output logic [STATE_W-1:0] state_o,
  output logic               busy_o
);
  logic [STATE_W-1:0] state_q;
  logic               busy_q;
  logic               differs;
  logic [1:0]         age_q;

  assign differs = (next_i != state_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= '0;
      busy_q  <= 1'b0;
      age_q   <= '0;
    end else begin
      state_q <= next_i;
      busy_q  <= differs;
      if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end
  end

  assign state_o = state_q;
  assign busy_o  = busy_q;

  // R4: a busy cycle only follows a real change of state
  p_busy_means_change_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (state_q != $past(state_q)));

  // R2: with the neighbours held, the state cannot move (own state is not an input)
  p_steady_neighbours_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 2'd2 && north_i == $past(north_i) && west_i == $past(west_i))
      |=> $stable(state_q));
endmodule

// File: rtl/ca_exec_unit.sv
module ca_exec_unit #(
  parameter int unsigned NUM_IN  = ca_cell_pkg::DEF_NUM_IN,
  parameter int unsigned NUM_OUT = ca_cell_pkg::DEF_NUM_OUT
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            busy_i,
  input  logic [NUM_OUT*(1<<NUM_IN)-1:0]  cfg_i,
  input  logic [NUM_IN-1:0]               logic_i,
  output logic [NUM_OUT*(1<<NUM_IN)-1:0]  exec_o,
  output logic [NUM_OUT-1:0]              logic_o
);
  localparam int unsigned TT_W  = 1 << NUM_IN;
  localparam int unsigned CFG_W = NUM_OUT * TT_W;

  logic [CFG_W-1:0]   exec_q;
  logic [NUM_OUT-1:0] out_q;
  logic [NUM_OUT-1:0] eval_w;

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_eval
    logic [TT_W-1:0] tab;
    assign tab       = exec_q[o*TT_W +: TT_W];
    assign eval_w[o] = tab[logic_i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exec_q <= '0;
      out_q  <= '0;
    end else begin
      if (busy_i) exec_q <= cfg_i;
      else        out_q  <= eval_w;
    end
  end

  assign exec_o  = exec_q;
  assign logic_o = out_q;

  // R6: outputs frozen across a reload cycle
  p_hold_while_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> $stable(out_q));

  // R8: execution table untouched when no reload is pending
  p_no_reload_when_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_i |=> $stable(exec_q));
endmodule

// File: rtl/ca_logic_cell.sv
module ca_logic_cell #(
  parameter int unsigned STATE_W = ca_cell_pkg::DEF_STATE_W,
  parameter int unsigned NUM_IN  = ca_cell_pkg::DEF_NUM_IN,
  parameter int unsigned NUM_OUT = ca_cell_pkg::DEF_NUM_OUT
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STATE_W-1:0] north_state_i,
  input  logic [STATE_W-1:0] west_state_i,
  output logic [STATE_W-1:0] east_state_o,
  output logic [STATE_W-1:0] south_state_o,
  input  logic [NUM_IN-1:0]  logic_i,
  output logic [NUM_OUT-1:0] logic_o,
  output logic               reload_busy_o
);
  localparam int unsigned CFG_W = NUM_OUT * (1 << NUM_IN);

  logic [STATE_W-1:0] next_w;
  logic [STATE_W-1:0] state_w;
  logic               busy_w;
  logic [CFG_W-1:0]   cfg_w;
  logic [CFG_W-1:0]   exec_w;

  ca_rule_lut #(.STATE_W(STATE_W)) u_rule (
    .north_i(north_state_i), .west_i(west_state_i), .next_o(next_w));

  ca_reload_ctrl #(.STATE_W(STATE_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .north_i(north_state_i), .west_i(west_state_i),
    .next_i(next_w), .state_o(state_w), .busy_o(busy_w));

  ca_func_store #(.STATE_W(STATE_W), .NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT)) u_store (
    .state_i(state_w), .cfg_o(cfg_w));

  ca_exec_unit #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT)) u_exec (
    .clk(clk), .rst_n(rst_n), .busy_i(busy_w), .cfg_i(cfg_w),
    .logic_i(logic_i), .exec_o(exec_w), .logic_o(logic_o));

  assign east_state_o  = state_w;
  assign south_state_o = state_w;
  assign reload_busy_o = busy_w;

  // R7: outside a reload the active table matches the stored word for the state
  p_exec_tracks_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_w |-> (exec_w == cfg_w));

  // R5: state 0 always runs the all-zero function once loaded
  p_idle_function_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_w && state_w == '0) |-> (exec_w == '0));
endmodule

// File: tb/ca_logic_cell_tb_top.sv
module ca_logic_cell_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n;
  logic [3:0] north, west, east, south;
  logic [1:0] lin, lout;
  logic       busy;

  int n_checks = 0;
  int n_fail   = 0;

  ca_logic_cell dut_i (
    .clk(clk), .rst_n(rst_n), .north_state_i(north), .west_state_i(west),
    .east_state_o(east), .south_state_o(south), .logic_i(lin),
    .logic_o(lout), .reload_busy_o(busy));

  typedef struct {
    logic [3:0] st;
    logic       bsy;
    logic [1:0] lo;
    string      tag;
  } exp_t;
  exp_t sb_q[$];

  logic [3:0] m_state = '0;
  logic       m_busy  = 1'b0;
  logic [7:0] m_exec  = '0;
  logic [1:0] m_out   = '0;

  function automatic logic [3:0] rule_m(logic [3:0] n, logic [3:0] w);
    return 4'((n + 2 * w + 1) % 16);
  endfunction

  function automatic logic [7:0] cfg_m(logic [3:0] s);
    if (s == 0) return 8'h00;
    return {~s, s};
  endfunction

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Driver: apply inputs, clock once, advance the requirement model, queue expectation
  task automatic step(logic [3:0] n, logic [3:0] w, logic [1:0] li, string tag);
    logic [3:0] ns;
    north = n; west = w; lin = li;
    @(posedge clk);
    #1;
    ns = rule_m(n, w);
    if (!m_busy) m_out = {m_exec[4 + li], m_exec[li]};
    if (m_busy)  m_exec = cfg_m(m_state);
    m_busy  = (ns != m_state);
    m_state = ns;
    sb_q.push_back('{st: m_state, bsy: m_busy, lo: m_out, tag: tag});
  endtask

  // Monitor: compare at the falling edge
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      check("R2", int'(east), int'(e.st));
      check("R3", int'(south), int'(east));
      check("R4", int'(busy), int'(e.bsy));
      check(e.tag, int'(lout), int'(e.lo));
    end
  end

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; north = 4'd9; west = 4'd3; lin = 2'd3;
    repeat (3) @(posedge clk);
    #2;
    check("R1", int'(east), 0);
    check("R1", int'(busy), 0);
    check("R1", int'(lout), 0);
    rst_n = 1'b1;

    // R8: leave state 0 for state 1, then hold neighbours and sweep inputs
    for (int i = 0; i < 6; i++) step(4'd0, 4'd0, 2'(i), "R8");
    // R5: XOR table (state 6)
    step(4'd5, 4'd0, 2'd0, "R7");
    step(4'd5, 4'd0, 2'd1, "R7");
    for (int i = 0; i < 5; i++) step(4'd5, 4'd0, 2'(i), "R5");
    // R5: AND table (state 8) via a different neighbour pair
    step(4'd3, 4'd2, 2'd3, "R7");
    for (int i = 0; i < 5; i++) step(4'd3, 4'd2, 2'(i + 1), "R5");
    // R5: OR table (state 14)
    step(4'd13, 4'd0, 2'd0, "R7");
    for (int i = 0; i < 5; i++) step(4'd13, 4'd0, 2'(3 - i), "R5");
    // R5: back to idle state 0 (15 + 0 + 1 wraps)
    step(4'd15, 4'd0, 2'd2, "R7");
    for (int i = 0; i < 4; i++) step(4'd15, 4'd0, 2'(i), "R5");
    // R6: flip inputs while a reload is in progress
    step(4'd5, 4'd0, 2'd1, "R6");
    step(4'd5, 4'd0, 2'd2, "R6");
    step(4'd5, 4'd0, 2'd3, "R6");
    step(4'd5, 4'd0, 2'd0, "R6");
    // R9: back-to-back changes, last one wins
    step(4'd1, 4'd0, 2'd1, "R9");
    step(4'd7, 4'd0, 2'd2, "R9");
    step(4'd2, 4'd5, 2'd3, "R9");
    step(4'd13, 4'd0, 2'd0, "R9");
    for (int i = 0; i < 5; i++) step(4'd13, 4'd0, 2'(i), "R9");
    // R2: same neighbour pair from different present states
    step(4'd3, 4'd2, 2'd1, "R2");
    step(4'd9, 4'd1, 2'd2, "R2");
    step(4'd3, 4'd2, 2'd3, "R2");
    for (int i = 0; i < 3; i++) step(4'd3, 4'd2, 2'(i), "R2");

    @(posedge clk);
    @(negedge clk);
    #1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule